// File: doc/BRIEF.md
# Four-Channel Bus DMA Controller

This block moves single bytes between peripherals and memory on behalf of four requesters, so the processor need not copy the data itself. Each channel holds a start address, a byte count and a direction. These are loaded through a one-cycle configuration write. A peripheral raises its request line. The controller then asks the processor for the bus with a hold request and waits for the hold acknowledge. Only after that does it drive the memory address, the address-enable flag and the acknowledge line of the served channel.

Each byte takes five clocks. The first clock presents the address with no strobes. The next four pair a memory strobe with the I/O strobe of the opposite sense. After each byte the channel's address steps up and its count steps down. The bus is given back as soon as the served request is gone or the channel reaches terminal count. When several requests are waiting, the lowest-numbered enabled channel wins.

Top module: `bus_dma_ctrl`

## Requirements
- R1: During and right after reset, hrq, aen, dack, all four strobes, tc and mem_addr are all zero.
- R2: An enabled pending request raises hrq. aen, dack and the strobes stay low until hlda has been sampled high while hrq is high.
- R3: At grant, the channel served is the lowest-numbered one whose request is high and whose enable is set. Requests on disabled channels are ignored.
- R4: Every byte is one clock with aen and dack high and no strobe, followed by exactly STB_CYC (default 4) clocks with strobes.
- R5: Direction bit 0 moves device to memory and asserts ior with memw. Direction bit 1 moves memory to device and asserts memr with iow. The other two strobes stay low.
- R6: While aen is high, exactly one dack bit is set, the one of the served channel, and mem_addr equals that channel's current address.
- R7: After each completed byte, the channel address rises by one (modulo 2^AW) and the count falls by one.
- R8: The byte started with count zero is the last one, so a programmed count N gives N+1 bytes. tc is high only in that byte's final strobe clock, and the channel then clears its enable.
- R9: After a byte, if the served request is still high and it was not the last byte, the next address clock follows at once. Otherwise hrq and aen are low on the next clock.
- R10: A request that falls during a byte does not shorten it: all strobe clocks complete before the bus is released.
- R11: If hlda falls while the bus is owned, aen, dack and the strobes are low by the next clock. The interrupted byte leaves address and count unchanged, so the retry uses the same address.
- R12: A configuration write (cfg_we with cfg_ch, cfg_addr, cfg_cnt, cfg_to_dev, cfg_en) loads that channel on the next edge. A write aimed at the channel currently in service is ignored, while writes to other channels take effect.
- R13: After releasing the bus, the controller raises no new hrq until hlda has gone low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | $clog2(NCH) | Channel written |
| cfg_addr | input | AW | Start address |
| cfg_cnt | input | CW | Byte count minus one |
| cfg_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| cfg_en | input | 1 | Channel enable |
| drq | input | NCH | Peripheral transfer requests |
| hlda | input | 1 | Hold acknowledge from the processor |
| hrq | output | 1 | Hold request to the processor |
| aen | output | 1 | DMA address on the bus |
| dack | output | NCH | Per-channel acknowledge |
| mem_addr | output | AW | Memory address |
| memr | output | 1 | Memory read strobe |
| memw | output | 1 | Memory write strobe |
| ior | output | 1 | I/O read strobe |
| iow | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count pulse |

## Verification
The hardest situation to reach is a loss of bus ownership in the middle of a byte, because a well-behaved processor never withdraws hlda while hrq is high. The bench's processor model has a forcing mode that pulls hlda low during the second strobe clock. It then checks that the retried byte reuses the same address. A second mode holds hlda high after release, with another enabled request waiting, to show that hrq stays quiet. A write to the channel in service is issued directly while that channel's strobes are active. Random request toggling with random hold delays then covers releases, continuations and priority contests.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_SETUP = 3'd2,
      ST_STRB  = 3'd3,
      ST_REL   = 3'd4
   } dma_state_t;
endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] waddr,
   input  logic [CW-1:0] wcnt,
   input  logic          wdir,
   input  logic          wen,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic [CW-1:0] cnt,
   output logic          dir,
   output logic          en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         cnt  <= '0;
         dir  <= 1'b0;
         en   <= 1'b0;
      end else if (wr) begin
         addr <= waddr;
         cnt  <= wcnt;
         dir  <= wdir;
         en   <= wen;
      end else if (step) begin
         addr <= addr + 1'b1;
         cnt  <= cnt - 1'b1;
         if (cnt == '0) en <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_prio.sv
module dma_prio #(
   parameter  int NCH = 4,
   localparam int CHW = $clog2(NCH)
) (
   input  logic [NCH-1:0] req,
   output logic           any,
   output logic [CHW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) idx = CHW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
#(
   parameter  int NCH     = 4,
   parameter  int STB_CYC = 4,
   localparam int CHW     = $clog2(NCH),
   localparam int PHW     = $clog2(STB_CYC + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pend_any,
   input  logic [CHW-1:0] pick,
   input  logic           hlda,
   input  logic           act_drq,
   input  logic           cnt_zero,
   output dma_state_t     state,
   output logic [CHW-1:0] ch,
   output logic           step,
   output logic           tc
);
   logic [PHW-1:0] ph;
   logic           last;
   logic           cont;

   assign last = (state == ST_STRB) && (ph == PHW'(STB_CYC - 1));
   assign step = last && hlda;
   assign tc   = step && cnt_zero;
   assign cont = act_drq && !cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ph    <= '0;
         ch    <= '0;
      end else begin
         case (state)
            ST_IDLE:  if (pend_any) state <= ST_WAIT;
            ST_WAIT: begin
               if (hlda) begin
                  if (pend_any) begin
                     state <= ST_SETUP;
                     ch    <= pick;
                  end else begin
                     state <= ST_REL;
                  end
               end else if (!pend_any) begin
                  state <= ST_IDLE;
               end
            end
            ST_SETUP: begin
               ph <= '0;
               state <= hlda ? ST_STRB : ST_REL;
            end
            ST_STRB: begin
               if (!hlda)     state <= ST_REL;
               else if (last) state <= cont ? ST_SETUP : ST_REL;
               else           ph <= ph + 1'b1;
            end
            ST_REL:   if (!hlda) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bus_dma_ctrl.sv
module bus_dma_ctrl
   import dma_pkg::*;
#(
   parameter  int NCH     = 4,
   parameter  int AW      = 16,
   parameter  int CW      = 16,
   parameter  int STB_CYC = 4,
   localparam int CHW     = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic [CHW-1:0] cfg_ch,
   input  logic [AW-1:0]  cfg_addr,
   input  logic [CW-1:0]  cfg_cnt,
   input  logic           cfg_to_dev,
   input  logic           cfg_en,
   input  logic [NCH-1:0] drq,
   input  logic           hlda,
   output logic           hrq,
   output logic           aen,
   output logic [NCH-1:0] dack,
   output logic [AW-1:0]  mem_addr,
   output logic           memr,
   output logic           memw,
   output logic           ior,
   output logic           iow,
   output logic           tc
);
   if (NCH < 2 || (1 << CHW) != NCH) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (STB_CYC < 1 || STB_CYC > 64) begin : g_bad_stb
      $error("STB_CYC must lie in 1..64");
   end
   if (AW < 1 || CW < 1) begin : g_bad_w
      $error("AW and CW must be positive");
   end

   dma_state_t     state;
   logic [CHW-1:0] act_ch;
   logic           step, own, strb;
   logic [NCH-1:0] en_v, dir_v, pend;
   logic [AW-1:0]  addr_a [NCH];
   logic [CW-1:0]  cnt_a  [NCH];
   logic           pend_any;
   logic [CHW-1:0] pick;

   assign own  = (state == ST_SETUP) || (state == ST_STRB);
   assign strb = (state == ST_STRB);

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic hit;
      assign hit = (act_ch == CHW'(g));
      dma_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (cfg_we && cfg_ch == CHW'(g) && !(own && hit)),
         .waddr (cfg_addr),
         .wcnt  (cfg_cnt),
         .wdir  (cfg_to_dev),
         .wen   (cfg_en),
         .step  (step && hit),
         .addr  (addr_a[g]),
         .cnt   (cnt_a[g]),
         .dir   (dir_v[g]),
         .en    (en_v[g])
      );
   end

   assign pend = drq & en_v;

   dma_prio #(.NCH(NCH)) u_prio (
      .req (pend),
      .any (pend_any),
      .idx (pick)
   );

   dma_seq #(.NCH(NCH), .STB_CYC(STB_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_any (pend_any),
      .pick     (pick),
      .hlda     (hlda),
      .act_drq  (drq[act_ch]),
      .cnt_zero (cnt_a[act_ch] == '0),
      .state    (state),
      .ch       (act_ch),
      .step     (step),
      .tc       (tc)
   );

   assign hrq      = (state == ST_WAIT) || own;
   assign aen      = own;
   assign dack     = own ? (NCH'(1) << act_ch) : '0;
   assign mem_addr = own ? addr_a[act_ch] : '0;
   assign ior      = strb && !dir_v[act_ch];
   assign memw     = strb && !dir_v[act_ch];
   assign memr     = strb &&  dir_v[act_ch];
   assign iow      = strb &&  dir_v[act_ch];
endmodule

// File: rtl/bus_dma_chk.sv
module bus_dma_chk #(
   parameter int NCH     = 4,
   parameter int AW      = 16,
   parameter int STB_CYC = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           hlda,
   input logic           hrq,
   input logic           aen,
   input logic [NCH-1:0] dack,
   input logic           memr,
   input logic           memw,
   input logic           ior,
   input logic           iow,
   input logic           tc
);
   logic       strobe;
   logic [7:0] run;
   assign strobe = memr | memw | ior | iow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run <= '0;
      else if (strobe) run <= run + 1'b1;
      else             run <= '0;
   end

   AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dack)); // R6
   AST_DACK_WITH_AEN: assert property (@(posedge clk) disable iff (!rst_n) aen |-> $onehot(dack)); // R6
   AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> ((ior && memw && !memr && !iow) || (memr && iow && !ior && !memw))); // R5
   AST_STROBE_IN_AEN: assert property (@(posedge clk) disable iff (!rst_n) strobe |-> aen); // R4
   AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> ($past(aen) && !$past(strobe))); // R4
   AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n) run <= 8'(STB_CYC)); // R4
   AST_GRANT_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aen) |-> ($past(hlda) && $past(hrq))); // R2
   AST_AEN_HOLDS_HRQ: assert property (@(posedge clk) disable iff (!rst_n) aen |-> hrq); // R2
   AST_HLDA_LOSS: assert property (@(posedge clk) disable iff (!rst_n) (aen && !hlda) |=> !aen); // R11
   AST_TC_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n) tc |-> strobe); // R8
   AST_NO_REGRAB: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hrq) && hlda) |=> !hrq); // R13
endmodule

bind bus_dma_ctrl bus_dma_chk #(.NCH(NCH), .AW(AW), .STB_CYC(STB_CYC)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .hlda  (hlda),
   .hrq   (hrq),
   .aen   (aen),
   .dack  (dack),
   .memr  (memr),
   .memw  (memw),
   .ior   (ior),
   .iow   (iow),
   .tc    (tc)
);

// File: tb/sim_bus_dma_ctrl.sv
module sim_bus_dma_ctrl;
   localparam int NCH = 4, AW = 16, CW = 16, STB = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          cfg_we = 0, cfg_to_dev = 0, cfg_en = 0, hlda = 0;
   logic [1:0]    cfg_ch = 0;
   logic [AW-1:0] cfg_addr = 0;
   logic [CW-1:0] cfg_cnt = 0;
   logic [3:0]    drq = 0;
   logic          hrq, aen, memr, memw, ior, iow, tc;
   logic [3:0]    dack;
   logic [AW-1:0] mem_addr;

   bus_dma_ctrl #(.NCH(NCH), .AW(AW), .CW(CW), .STB_CYC(STB)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr),
      .cfg_cnt(cfg_cnt), .cfg_to_dev(cfg_to_dev), .cfg_en(cfg_en), .drq(drq), .hlda(hlda),
      .hrq(hrq), .aen(aen), .dack(dack), .mem_addr(mem_addr), .memr(memr), .memw(memw),
      .ior(ior), .iow(iow), .tc(tc));

   int n_chk = 0, n_bad = 0;
   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // reference model of channel state
   logic [AW-1:0] m_addr [4];
   logic [CW-1:0] m_cnt  [4];
   bit            m_dir  [4];
   bit            m_en   [4];
   int            bytes  [4];

   function automatic int lowest(logic [3:0] v);
      for (int i = 0; i < 4; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic tick();
      @(posedge clk); #5;
   endtask

   task automatic wr(int c, int a, int n, bit d, bit e, bit apply);
      cfg_we = 1; cfg_ch = 2'(c); cfg_addr = AW'(a); cfg_cnt = CW'(n);
      cfg_to_dev = d; cfg_en = e;
      tick();
      cfg_we = 0;
      if (apply) begin
         m_addr[c] = AW'(a); m_cnt[c] = CW'(n); m_dir[c] = d; m_en[c] = e;
      end
   endtask

   task automatic idle();
      int q = 0;
      while (q < 4) begin
         tick();
         if (hrq || hlda || aen) q = 0; else q++;
      end
   endtask

   // processor hold model: 0 auto with random delay, 1 force low, 2 grant and keep
   int hmode = 0, hdly = 0;
   always @(posedge clk) begin
      #5;
      if (!rst_n) hlda = 0;
      else if (hmode == 1) hlda = 0;
      else if (hmode == 2) begin if (hrq) hlda = 1; end
      else if (hrq != hlda) begin
         if (hdly == 0) begin hlda = hrq; hdly = $urandom_range(0, 3); end
         else hdly--;
      end
   end

   // cycle monitor
   bit p_aen = 0, p_str = 0, p_hlda = 0, p_hrq = 0, aft = 0, cont = 0;
   logic [3:0] p_pend = 0;
   int run = 0, cur = 0;
   always @(negedge clk) begin
      logic [3:0] pend;
      bit str, tcx;
      int g;
      if (rst_n) begin
         str = memr | memw | ior | iow;
         for (int i = 0; i < 4; i++) pend[i] = drq[i] & m_en[i];
         if (aft) begin
            aft = 0;
            if (cont) chk(aen && !str && dack == 4'(1 << cur), "R9 continue", int'(dack), 1 << cur);
            else      chk(!aen && !hrq, "R9 release", int'({hrq, aen}), 0);
         end
         if (aen && !p_aen) begin
            chk(p_hlda && p_hrq, "R2 grant before hlda", int'(p_hlda), 1);
            g = lowest(p_pend);
            chk(g >= 0 && dack == 4'(1 << g), "R3 priority", int'(dack), g < 0 ? 0 : (1 << g));
            if (g >= 0) cur = g;
         end
         if (aen) begin
            chk(dack == 4'(1 << cur), "R6 dack", int'(dack), 1 << cur);
            chk(mem_addr == m_addr[cur], "R6 R7 address", int'(mem_addr), int'(m_addr[cur]));
            if (!str && p_aen && !p_str) chk(0, "R4 setup longer than one", 2, 1);
         end else begin
            chk(dack == 0 && !str, "R6 idle bus", int'(dack), 0);
         end
         if (str) begin
            if (!p_str) chk(p_aen, "R4 setup before strobes", int'(p_aen), 1);
            run++;
            if (m_dir[cur]) chk(memr && iow && !ior && !memw, "R5 mem to dev", int'({memr, memw, ior, iow}), 4'b1001);
            else            chk(ior && memw && !memr && !iow, "R5 dev to mem", int'({memr, memw, ior, iow}), 4'b0110);
            if (run == STB) begin
               tcx = (m_cnt[cur] == 0);
               chk(tc == tcx, "R8 tc", int'(tc), int'(tcx));
               m_addr[cur]++; m_cnt[cur]--;
               if (tcx) m_en[cur] = 0;
               bytes[cur]++;
               cont = drq[cur] && !tcx;
               aft = 1; run = 0;
            end else begin
               chk(!tc, "R8 tc early", int'(tc), 0);
            end
         end else begin
            if (p_str && run != 0) begin
               if (!p_hlda) chk(!aen, "R11 stop after hlda loss", int'(aen), 0);
               else         chk(0, "R4 short byte", run, STB);
               run = 0;
            end
            chk(!tc, "R8 tc outside strobe", int'(tc), 0);
         end
         p_aen = aen; p_str = str; p_hlda = hlda; p_hrq = hrq; p_pend = pend;
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      int b0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) begin m_addr[i] = 0; m_cnt[i] = 0; m_dir[i] = 0; m_en[i] = 0; bytes[i] = 0; end
      repeat (3) tick();
      chk(!hrq && !aen && dack == 0 && !tc && mem_addr == 0 && !(memr | memw | ior | iow),
          "R1 in reset", int'({hrq, aen, dack}), 0);
      rst_n = 1;
      tick();
      chk(!hrq && !aen && dack == 0 && !tc && mem_addr == 0, "R1 after reset", int'({hrq, aen, dack}), 0);

      // R3: disabled ch0 ignored, ch1 beats ch2
      wr(0, 16'h0010, 0, 0, 0, 1);
      wr(1, 16'h1000, 1, 0, 1, 1);
      wr(2, 16'h2000, 0, 1, 1, 1);
      drq = 4'b0111;
      while (!aen) tick();
      chk(dack == 4'b0010, "R3 lowest enabled wins", int'(dack), 2);
      while (bytes[2] < 1) tick();
      drq = 0;
      idle();
      chk(bytes[1] == 2, "R8 count one gives two bytes", bytes[1], 2);
      chk(bytes[0] == 0, "R3 disabled channel served", bytes[0], 0);

      // R10: request drops mid-byte
      wr(3, 16'h0300, 5, 1, 1, 1);
      drq = 4'b1000;
      while (!(memr | memw | ior | iow)) tick();
      drq = 0;
      idle();
      chk(bytes[3] == 1, "R10 byte completes after drop", bytes[3], 1);

      // R11: hold acknowledge withdrawn mid-byte
      wr(0, 16'h0100, 5, 0, 1, 1);
      b0 = bytes[0];
      drq = 4'b0001;
      while (!(memr | memw | ior | iow)) tick();
      tick();
      hmode = 1;
      tick(); tick();
      chk(!aen, "R11 bus dropped", int'(aen), 0);
      chk(bytes[0] == b0, "R11 no byte counted", bytes[0], b0);
      hmode = 0;
      while (!aen) tick();
      chk(mem_addr == 16'h0100, "R11 retry same address", int'(mem_addr), 16'h0100);
      drq = 0;
      idle();

      // R12: write to channel in service ignored, other channel accepted
      wr(1, 16'h0200, 2, 1, 1, 1);
      b0 = bytes[1];
      drq = 4'b0010;
      while (!(memr | memw | ior | iow)) tick();
      wr(1, 16'h3333, 9, 0, 1, 0);
      wr(3, 16'h3400, 0, 1, 1, 1);
      while (m_en[1]) tick();
      drq = 0;
      idle();
      chk(bytes[1] - b0 == 3, "R12 ignored write kept count", bytes[1] - b0, 3);
      b0 = bytes[3];
      drq = 4'b1000;
      while (bytes[3] == b0) tick();
      drq = 0;
      idle();
      chk(!m_en[3], "R12 R8 accepted write served", int'(m_en[3]), 0);

      // R13: no new request while hlda still high after release
      hmode = 2;
      wr(0, 16'h0500, 0, 0, 1, 1);
      wr(2, 16'h0600, 0, 1, 1, 1);
      drq = 4'b0101;
      while (m_en[0]) tick();
      tick(); tick();
      for (int k = 0; k < 5; k++) begin
         chk(!hrq && hlda, "R13 hrq quiet until hlda low", int'(hrq), 0);
         tick();
      end
      hmode = 0;
      while (m_en[2]) tick();
      drq = 0;
      idle();

      // random traffic
      for (int it = 0; it < 600; it++) begin
         if (!hrq && !hlda && $urandom_range(0, 3) == 0)
            wr($urandom_range(0, 3), $urandom_range(0, 65535), $urandom_range(0, 3),
               1'($urandom_range(0, 1)), 1, 1);
         for (int b = 0; b < 4; b++) if ($urandom_range(0, 3) == 0) drq[b] = ~drq[b];
         tick();
      end
      drq = 0;
      idle();
      finish_run();
   end
endmodule